// File: doc/BRIEF.md
# SMIC Host Transaction Controller

This block runs one request/response exchange with a management controller through a three-register byte port, acting as the host side. The port has a data register at offset 0, a control/status register at offset 1 and a flags register at offset 2. Before it starts, the caller loads the request bytes into internal storage. The controller then walks the write handshake (write start, write next, write end) and the read handshake (read start, read next, read end). Every step is checked against the status code that echoes the previous command and against the handshake flags. The reply bytes are kept internally. The caller reads them back through a shaping view that applies its own buffer capacity.

Any unexpected status, a non-zero completion byte or a stalled step restarts the exchange from its first command. A bounded number of restarts is allowed. After that the controller drops into a failed state, which reports a failure pulse and returns to idle. While idle, the controller keeps polling the flags register. From these reads it reports a pending message (attention) and a missing device (a flags read of all ones).

The register port is a simple synchronous bus. One access is made per cycle and read data returns in the same cycle.

Top module: `smic_host_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy_o`, `done_o`, `fail_o` and `attn_o` are 0. While idle it issues only reads of the flags register (offset 2) and never a bus write.
- R2: A start request is accepted (`start_ack_o`) only when its length is between 2 and `MAX_LEN` (80) inclusive and the controller is idle or failed. Otherwise `start_err_o` pulses in the same cycle and the controller state is unchanged.
- R3: Each step reads flags first and, while flags bit 0 (busy) is 1, issues no command and reads flags again. Every command is followed by a write of the flags register with bit 0 set.
- R4: The request goes out as control code 0x40 (get status, expecting status 0xC0) and 0x41 with byte 0. Each later byte is sent with 0x42, or 0x43 for the last byte, and only while flags bit 6 (transmit ready) is 1. Bytes go to the data register in load order.
- R5: After status 0xC3 with data 0x00, the controller waits for flags bit 7 (receive ready) and issues 0x44. It stores a byte and issues 0x45 on status 0xC4 or 0xC5 with bit 7 set, and stores the last byte and issues 0x46 on status 0xC6. `done_o` pulses once status 0xC0 is seen with data 0x00.
- R6: A status other than the expected one, or a non-zero data byte after write end or read end, restarts the exchange at get status, with the original length and cleared positions.
- R7: When a fourth restart is needed (more than `MAX_RETRY` = 3 retries), the controller enters the failed state. On the next cycle it pulses `fail_o` and returns to idle.
- R8: If `TIMEOUT_CYC` cycles pass without a completed step, the exchange restarts as in R6. A step that completes within the window causes no restart.
- R9: Reply bytes beyond `MAX_LEN` are read from the port and discarded, and the reply is marked truncated, so result byte 2 reads 0xC6.
- R10: If `res_cap_i` is smaller than the stored reply length, `res_len_o` equals `res_cap_i` and result byte 2 reads 0xC6.
- R11: If the stored reply is shorter than 3 bytes and `res_cap_i` is at least 3, `res_len_o` is 3 and result byte 2 reads 0xFF.
- R12: While idle, `attn_o` follows flags bit 2 (message available). Flags bits 3 and 4 have no effect on it.
- R13: While idle, `absent_o` is 1 exactly when the last flags read was 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_we_i | input | 1 | Write one request byte into storage |
| ld_addr_i | input | AW (7) | Request byte index |
| ld_data_i | input | 8 | Request byte value |
| start_i | input | 1 | Start an exchange |
| start_len_i | input | LW (8) | Request length in bytes |
| start_ack_o | output | 1 | Start accepted (same cycle) |
| start_err_o | output | 1 | Start rejected (same cycle) |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | Exchange completed (one-cycle pulse) |
| fail_o | output | 1 | Retries exhausted (one-cycle pulse) |
| attn_o | output | 1 | Device has a message pending |
| absent_o | output | 1 | Flags read as all ones |
| res_cap_i | input | LW (8) | Caller buffer capacity |
| res_addr_i | input | AW (7) | Result byte index |
| res_len_o | output | LW (8) | Result length after shaping |
| res_data_o | output | 8 | Result byte at `res_addr_i` |
| bus_req_o | output | 1 | Register access this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 2 | Register offset |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, same cycle |

## Verification
On every cycle, the embedded properties check the following:
- every flags write carries the busy bit;
- every control write is a legal code;
- no write is issued while idle or while a busy flag is read;
- the retry count stays within its bound;
- the failed state always leads to a failure pulse;
- the reply fill never passes `MAX_LEN`.

Several behaviours need whole exchanges against a modelled device, so only the bench's scenarios can show them. These are the exact command order for a given request and reply length, the restart counts for a one-shot and a persistent error, the timeout window, and the shaping of byte 2 and the length for overflowing, truncated and short replies.

// File: rtl/smic_host_pkg.sv
package smic_host_pkg;
  localparam logic [1:0] OFS_DATA  = 2'd0;
  localparam logic [1:0] OFS_CS    = 2'd1;
  localparam logic [1:0] OFS_FLAGS = 2'd2;

  localparam int FB_RX   = 7;
  localparam int FB_TX   = 6;
  localparam int FB_MSG  = 2;
  localparam int FB_BUSY = 0;

  localparam logic [7:0] CC_GET_STATUS = 8'h40;
  localparam logic [7:0] CC_WR_START   = 8'h41;
  localparam logic [7:0] CC_WR_NEXT    = 8'h42;
  localparam logic [7:0] CC_WR_END     = 8'h43;
  localparam logic [7:0] CC_RD_START   = 8'h44;
  localparam logic [7:0] CC_RD_NEXT    = 8'h45;
  localparam logic [7:0] CC_RD_END     = 8'h46;

  localparam logic [7:0] SC_READY    = 8'hC0;
  localparam logic [7:0] SC_WR_START = 8'hC1;
  localparam logic [7:0] SC_WR_NEXT  = 8'hC2;
  localparam logic [7:0] SC_WR_END   = 8'hC3;
  localparam logic [7:0] SC_RD_START = 8'hC4;
  localparam logic [7:0] SC_RD_NEXT  = 8'hC5;
  localparam logic [7:0] SC_RD_END   = 8'hC6;

  localparam logic [7:0] RES_TRUNC  = 8'hC6;
  localparam logic [7:0] RES_UNSPEC = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_PROBE, ST_WSTART, ST_WNEXT, ST_WEND,
    ST_TURN, ST_RSTART, ST_RNEXT, ST_REND, ST_DEAD
  } xact_st_e;

  typedef enum logic [2:0] {
    PH_POLL, PH_STAT, PH_DREAD, PH_CMD, PH_BYTE, PH_HS
  } step_ph_e;

  typedef enum logic [1:0] {
    DM_STORE, DM_WCHK, DM_RCHK
  } dread_e;
endpackage

// File: rtl/smic_byte_store.sv
module smic_byte_store #(
  parameter int DEPTH = 80,
  parameter int AW    = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i < AW'(DEPTH))) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (raddr_i < AW'(DEPTH)) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/smic_tmo_timer.sv
module smic_tmo_timer #(
  parameter int TIMEOUT_CYC = 200000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= CW'(TIMEOUT_CYC);
    else if (load_i)                   cnt_q <= CW'(TIMEOUT_CYC);
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/smic_result_view.sv
module smic_result_view
  import smic_host_pkg::*;
#(
  parameter int AW = 7,
  parameter int LW = 8
) (
  input  logic [LW-1:0] fill_i,
  input  logic          trunc_i,
  input  logic [LW-1:0] cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    mem_data_i,
  output logic [LW-1:0] len_o,
  output logic [7:0]    data_o
);
  logic          cut, tr, shrt;
  logic [LW-1:0] len_c;

  always_comb begin
    cut   = cap_i < fill_i;
    len_c = cut ? cap_i : fill_i;
    tr    = trunc_i | cut;
    shrt  = (cap_i >= LW'(3)) && (len_c < LW'(3));
    len_o = shrt ? LW'(3) : len_c;
    if (addr_i == AW'(2) && tr)        data_o = RES_TRUNC;
    else if (addr_i == AW'(2) && shrt) data_o = RES_UNSPEC;
    else                               data_o = mem_data_i;
  end
endmodule

// File: rtl/smic_host_ctrl.sv
module smic_host_ctrl
  import smic_host_pkg::*;
#(
  parameter int MAX_LEN     = 80,
  parameter int MAX_RETRY   = 3,
  parameter int TIMEOUT_CYC = 200000,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1) + 1,
  localparam int RW = $clog2(MAX_RETRY + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  input  logic          start_i,
  input  logic [LW-1:0] start_len_i,
  output logic          start_ack_o,
  output logic          start_err_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          attn_o,
  output logic          absent_o,
  input  logic [LW-1:0] res_cap_i,
  input  logic [AW-1:0] res_addr_i,
  output logic [LW-1:0] res_len_o,
  output logic [7:0]    res_data_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i
);
  xact_st_e      st_q, st_d, nxt_q, nxt_d;
  step_ph_e      ph_q, ph_d;
  dread_e        dm_q, dm_d;
  logic [7:0]    flags_q, flags_d, cmd_q, cmd_d;
  logic          cmd_byte_q, cmd_byte_d;
  logic [LW-1:0] wpos_q, wpos_d, wcnt_q, wcnt_d, olen_q, olen_d, rpos_q, rpos_d;
  logic          trunc_q, trunc_d;
  logic [RW-1:0] retry_q, retry_d;
  logic          done_q, done_d, fail_q, fail_d, attn_q, attn_d, absent_q, absent_d;
  logic          active, start_ok, tmo_exp, tmo_load, recover, rbuf_we;
  logic [7:0]    wbuf_rd, rbuf_rd;
  logic [7:0]    exp_wst;

  assign active   = (st_q != ST_IDLE) && (st_q != ST_DEAD);
  assign start_ok = start_i && (start_len_i >= LW'(2)) && (start_len_i <= LW'(MAX_LEN))
                    && !active;
  assign start_ack_o = start_ok;
  assign start_err_o = start_i && !start_ok;
  assign busy_o   = active;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign attn_o   = attn_q;
  assign absent_o = absent_q;

  smic_byte_store #(.DEPTH(MAX_LEN), .AW(AW)) i_wbuf (
    .clk_i, .we_i(ld_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(wpos_q[AW-1:0]), .rdata_o(wbuf_rd)
  );

  smic_byte_store #(.DEPTH(MAX_LEN), .AW(AW)) i_rbuf (
    .clk_i, .we_i(rbuf_we), .waddr_i(rpos_q[AW-1:0]), .wdata_i(bus_rdata_i),
    .raddr_i(res_addr_i), .rdata_o(rbuf_rd)
  );

  smic_tmo_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_tmo (
    .clk_i, .rst_ni, .load_i(tmo_load), .run_i(active), .expired_o(tmo_exp)
  );

  smic_result_view #(.AW(AW), .LW(LW)) i_view (
    .fill_i(rpos_q), .trunc_i(trunc_q), .cap_i(res_cap_i), .addr_i(res_addr_i),
    .mem_data_i(rbuf_rd), .len_o(res_len_o), .data_o(res_data_o)
  );

  // bus access decoded from the step phase
  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = OFS_FLAGS;
    bus_wdata_o = 8'h00;
    unique case (ph_q)
      PH_POLL:  bus_req_o = (st_q != ST_DEAD) && !(active && tmo_exp);
      PH_STAT:  bus_addr_o = OFS_CS;
      PH_DREAD: bus_addr_o = OFS_DATA;
      PH_CMD:   begin bus_we_o = 1'b1; bus_addr_o = OFS_CS;   bus_wdata_o = cmd_q; end
      PH_BYTE:  begin bus_we_o = 1'b1; bus_addr_o = OFS_DATA; bus_wdata_o = wbuf_rd; end
      PH_HS:    begin bus_we_o = 1'b1; bus_wdata_o = flags_q | 8'h01; end
      default:  bus_req_o = 1'b0;
    endcase
  end

  assign exp_wst = (st_q == ST_WSTART) ? SC_WR_START : SC_WR_NEXT;

  always_comb begin
    st_d = st_q; nxt_d = nxt_q; ph_d = ph_q; dm_d = dm_q;
    flags_d = flags_q; cmd_d = cmd_q; cmd_byte_d = cmd_byte_q;
    wpos_d = wpos_q; wcnt_d = wcnt_q; olen_d = olen_q; rpos_d = rpos_q;
    trunc_d = trunc_q; retry_d = retry_q;
    attn_d = attn_q; absent_d = absent_q;
    done_d = 1'b0; fail_d = 1'b0;
    recover = 1'b0; tmo_load = 1'b0; rbuf_we = 1'b0;

    unique case (ph_q)
      PH_POLL: begin
        if (st_q == ST_IDLE) begin
          attn_d   = bus_rdata_i[FB_MSG];
          absent_d = (bus_rdata_i == 8'hFF);
        end else if (st_q == ST_DEAD) begin
          st_d = ST_IDLE; fail_d = 1'b1; retry_d = '0;
        end else if (tmo_exp) begin
          recover = 1'b1;
        end else if (!bus_rdata_i[FB_BUSY]) begin
          flags_d = bus_rdata_i;
          ph_d    = PH_STAT;
        end
      end
      PH_STAT: begin
        ph_d = PH_POLL;  // wait unless a command is chosen below
        unique case (st_q)
          ST_START: begin
            cmd_d = CC_GET_STATUS; cmd_byte_d = 1'b0; nxt_d = ST_PROBE; ph_d = PH_CMD;
          end
          ST_PROBE: begin
            if (bus_rdata_i != SC_READY) recover = 1'b1;
            else begin
              cmd_d = CC_WR_START; cmd_byte_d = 1'b1; nxt_d = ST_WSTART; ph_d = PH_CMD;
            end
          end
          ST_WSTART, ST_WNEXT: begin
            if (bus_rdata_i != exp_wst) recover = 1'b1;
            else if (flags_q[FB_TX]) begin
              cmd_byte_d = 1'b1; ph_d = PH_CMD;
              if (wcnt_q == LW'(1)) begin cmd_d = CC_WR_END;  nxt_d = ST_WEND;  end
              else                  begin cmd_d = CC_WR_NEXT; nxt_d = ST_WNEXT; end
            end
          end
          ST_WEND: begin
            if (bus_rdata_i != SC_WR_END) recover = 1'b1;
            else begin dm_d = DM_WCHK; ph_d = PH_DREAD; end
          end
          ST_TURN: begin
            if (flags_q[FB_RX]) begin
              cmd_d = CC_RD_START; cmd_byte_d = 1'b0; nxt_d = ST_RSTART; ph_d = PH_CMD;
            end
          end
          ST_RSTART: begin
            if (bus_rdata_i != SC_RD_START) recover = 1'b1;
            else if (flags_q[FB_RX]) begin
              dm_d = DM_STORE; cmd_d = CC_RD_NEXT; cmd_byte_d = 1'b0;
              nxt_d = ST_RNEXT; ph_d = PH_DREAD;
            end
          end
          ST_RNEXT: begin
            if (bus_rdata_i == SC_RD_END) begin
              dm_d = DM_STORE; cmd_d = CC_RD_END; cmd_byte_d = 1'b0;
              nxt_d = ST_REND; ph_d = PH_DREAD;
            end else if (bus_rdata_i == SC_RD_NEXT) begin
              if (flags_q[FB_RX]) begin
                dm_d = DM_STORE; cmd_d = CC_RD_NEXT; cmd_byte_d = 1'b0;
                nxt_d = ST_RNEXT; ph_d = PH_DREAD;
              end
            end else begin
              recover = 1'b1;
            end
          end
          ST_REND: begin
            if (bus_rdata_i != SC_READY) recover = 1'b1;
            else begin dm_d = DM_RCHK; ph_d = PH_DREAD; end
          end
          default: recover = 1'b1;
        endcase
      end
      PH_DREAD: begin
        unique case (dm_q)
          DM_STORE: begin
            if (rpos_q < LW'(MAX_LEN)) begin
              rbuf_we = 1'b1; rpos_d = rpos_q + 1'b1;
            end else begin
              trunc_d = 1'b1;  // overflow byte consumed and dropped
            end
            ph_d = PH_CMD;
          end
          DM_WCHK: begin
            if (bus_rdata_i != 8'h00) recover = 1'b1;
            else begin st_d = ST_TURN; tmo_load = 1'b1; ph_d = PH_POLL; end
          end
          DM_RCHK: begin
            if (bus_rdata_i != 8'h00) recover = 1'b1;
            else begin st_d = ST_IDLE; done_d = 1'b1; ph_d = PH_POLL; end
          end
          default: recover = 1'b1;
        endcase
      end
      PH_CMD:  ph_d = cmd_byte_q ? PH_BYTE : PH_HS;
      PH_BYTE: begin
        wpos_d = wpos_q + 1'b1; wcnt_d = wcnt_q - 1'b1; ph_d = PH_HS;
      end
      PH_HS: begin
        st_d = nxt_q; tmo_load = 1'b1; ph_d = PH_POLL;
      end
      default: ph_d = PH_POLL;
    endcase

    if (recover) begin
      ph_d = PH_POLL; tmo_load = 1'b1; retry_d = retry_q + 1'b1;
      if (retry_q >= RW'(MAX_RETRY)) begin
        st_d = ST_DEAD;
      end else begin
        st_d = ST_START; wpos_d = '0; wcnt_d = olen_q; rpos_d = '0; trunc_d = 1'b0;
      end
    end

    if (start_ok) begin
      st_d = ST_START; ph_d = PH_POLL; retry_d = '0; tmo_load = 1'b1;
      wpos_d = '0; wcnt_d = start_len_i; olen_d = start_len_i;
      rpos_d = '0; trunc_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; nxt_q <= ST_IDLE; ph_q <= PH_POLL; dm_q <= DM_STORE;
      flags_q <= '0; cmd_q <= '0; cmd_byte_q <= 1'b0;
      wpos_q <= '0; wcnt_q <= '0; olen_q <= '0; rpos_q <= '0;
      trunc_q <= 1'b0; retry_q <= '0;
      done_q <= 1'b0; fail_q <= 1'b0; attn_q <= 1'b0; absent_q <= 1'b0;
    end else begin
      st_q <= st_d; nxt_q <= nxt_d; ph_q <= ph_d; dm_q <= dm_d;
      flags_q <= flags_d; cmd_q <= cmd_d; cmd_byte_q <= cmd_byte_d;
      wpos_q <= wpos_d; wcnt_q <= wcnt_d; olen_q <= olen_d; rpos_q <= rpos_d;
      trunc_q <= trunc_d; retry_q <= retry_d;
      done_q <= done_d; fail_q <= fail_d; attn_q <= attn_d; absent_q <= absent_d;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !bus_we_o);
  // R2
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_ack_o && start_err_o));
  // R2
  start_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ack_o |=> (st_q == ST_START));
  // R3
  hs_busy_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == OFS_FLAGS) |-> bus_wdata_o[FB_BUSY]);
  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ph_q == PH_POLL && !tmo_exp && bus_rdata_i[FB_BUSY] && !start_i)
    |=> (ph_q == PH_POLL && !bus_we_o));
  // R4
  cmd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == OFS_CS)
    |-> (bus_wdata_o >= CC_GET_STATUS && bus_wdata_o <= CC_RD_END));
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_IDLE || st_q == ST_START));
  // R7
  retry_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RW'(MAX_RETRY + 1));
  // R7
  dead_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEAD && !start_i) |=> (fail_o && st_q == ST_IDLE));
  // R9
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpos_q <= LW'(MAX_LEN));
endmodule

// File: tb/test_smic_host_ctrl.sv
module test_smic_host_ctrl;
  localparam int TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_we = 1'b0; logic [6:0] ld_addr = '0; logic [7:0] ld_data = '0;
  logic start = 1'b0; logic [7:0] start_len = '0;
  logic start_ack, start_err, busy, done, fail, attn, absent;
  logic [7:0] res_cap = 8'd80; logic [6:0] res_addr = '0;
  logic [7:0] res_len, res_data;
  logic bus_req, bus_we; logic [1:0] bus_addr; logic [7:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  smic_host_ctrl #(.TIMEOUT_CYC(TMO)) i_smic_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .start_i(start), .start_len_i(start_len),
    .start_ack_o(start_ack), .start_err_o(start_err),
    .busy_o(busy), .done_o(done), .fail_o(fail), .attn_o(attn), .absent_o(absent),
    .res_cap_i(res_cap), .res_addr_i(res_addr), .res_len_o(res_len), .res_data_o(res_data),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] dv_flags = 8'h00, dv_status = 8'hC0, dv_data = 8'h00, dv_ctrl = 8'h00;
  logic [7:0] dv_side = 8'h00;
  bit dv_stuck = 0, dv_absent = 0;
  int dv_cnt = 0, dv_delay = 3, dv_rptr = 0, dv_bad_probe = 0, dv_wend_err = 0;
  byte unsigned dv_req[$], dv_resp[$];

  assign bus_rdata = dv_absent ? 8'hFF :
                     (bus_addr == 2'd0) ? dv_data :
                     (bus_addr == 2'd1) ? dv_status :
                     (dv_flags | dv_side | {7'd0, dv_stuck});

  always @(posedge clk) begin
    if (bus_req && bus_we) begin
      if (bus_addr == 2'd0) dv_req.push_back(bus_wdata);
      else if (bus_addr == 2'd1) dv_ctrl <= bus_wdata;
      else if (bus_wdata[0]) begin dv_flags[0] <= 1'b1; dv_cnt <= dv_delay; end
    end else if (dv_cnt > 0) begin
      dv_cnt <= dv_cnt - 1;
      if (dv_cnt == 1) begin
        dv_flags[0] <= 1'b0;
        case (dv_ctrl)
          8'h40: begin
            if (dv_bad_probe > 0) begin dv_status <= 8'hC5; dv_bad_probe <= dv_bad_probe - 1; end
            else dv_status <= 8'hC0;
            dv_flags[6] <= 1'b1; dv_flags[7] <= 1'b0;
          end
          8'h41: dv_status <= 8'hC1;
          8'h42: dv_status <= 8'hC2;
          8'h43: begin
            dv_status <= 8'hC3; dv_flags[7] <= 1'b1;
            if (dv_wend_err > 0) begin dv_data <= 8'h05; dv_wend_err <= dv_wend_err - 1; end
            else dv_data <= 8'h00;
          end
          8'h44: begin dv_status <= 8'hC4; dv_data <= dv_resp[0]; dv_rptr <= 1; end
          8'h45: begin
            dv_data <= dv_resp[dv_rptr];
            dv_status <= (dv_rptr == dv_resp.size() - 1) ? 8'hC6 : 8'hC5;
            dv_rptr <= dv_rptr + 1;
          end
          8'h46: begin dv_status <= 8'hC0; dv_data <= 8'h00; dv_flags[7] <= 1'b0; end
          default: dv_status <= 8'hC0;
        endcase
      end
    end
  end

  // ---------------- reference command stream, compared every clock ----------------
  byte unsigned exp_cmd[$];
  bit mon_on = 0;
  int n_probe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy && bus_we) chk("R1 write while not busy", 1, 0);
      if (bus_req && bus_we && bus_addr == 2'd2) chk("R3 flags write busy bit", int'(bus_wdata[0]), 1);
      if (bus_req && bus_we && bus_addr == 2'd1) begin
        if (bus_wdata == 8'h40) n_probe++;
        if (mon_on) begin
          if (exp_cmd.size() == 0) chk("R4/R5 unexpected command", int'(bus_wdata), 0);
          else chk("R4/R5 command order", int'(bus_wdata), int'(exp_cmd.pop_front()));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  byte unsigned req_q[$];

  task automatic load_req(int n, int seed);
    req_q.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 7'(i); ld_data = 8'((i * 13 + seed) & 8'hFF);
      req_q.push_back(ld_data);
    end
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic set_resp(int len);
    dv_resp.delete();
    for (int i = 0; i < len; i++) dv_resp.push_back(8'((8'h30 + i * 7) & 8'hFF));
  endtask

  task automatic build_exp(int n, int len);
    exp_cmd.delete();
    exp_cmd.push_back(8'h40); exp_cmd.push_back(8'h41);
    for (int i = 0; i < n - 2; i++) exp_cmd.push_back(8'h42);
    exp_cmd.push_back(8'h43); exp_cmd.push_back(8'h44);
    for (int i = 0; i < len - 1; i++) exp_cmd.push_back(8'h45);
    exp_cmd.push_back(8'h46);
  endtask

  task automatic do_start(int n, output bit acked);
    @(negedge clk);
    start = 1'b1; start_len = 8'(n);
    #1 acked = start_ack;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fail, output int cycles);
    got_done = 0; got_fail = 0; cycles = 0;
    while (!got_done && !got_fail && cycles < 20000) begin
      if (done) got_done = 1;
      if (fail) got_fail = 1;
      if (!got_done && !got_fail) begin @(negedge clk); cycles++; end
    end
  endtask

  task automatic read_res(int cap, int addr, output int len, output int data);
    res_cap = 8'(cap); res_addr = 7'(addr);
    #1 len = int'(res_len); data = int'(res_data);
  endtask

  task automatic full_xact(string tag, int n, int len, int seed);
    bit ok, gd, gf; int c, rl, rd;
    load_req(n, seed); set_resp(len); build_exp(n, len);
    dv_req.delete(); mon_on = 1;
    do_start(n, ok);
    chk({tag, " R2 start accepted"}, int'(ok), 1);
    wait_end(gd, gf, c);
    chk({tag, " R5 done"}, int'(gd), 1);
    mon_on = 0;
    chk({tag, " R4/R5 command stream consumed"}, exp_cmd.size(), 0);
    chk({tag, " R4 request byte count"}, dv_req.size(), n);
    for (int i = 0; i < n && i < dv_req.size(); i++)
      chk({tag, " R4 request byte"}, int'(dv_req[i]), int'(req_q[i]));
    read_res(80, 0, rl, rd);
    chk({tag, " R5 result length"}, rl, (len < 3) ? 3 : len);
    for (int i = 0; i < len && i < 80; i++) begin
      read_res(80, i, rl, rd);
      if (i != 2 || len >= 3) chk({tag, " R5 result byte"}, rd, int'(dv_resp[i]));
    end
  endtask

  // ---------------- scenarios ----------------
  initial begin
    bit ok, gd, gf; int c, rl, rd, p0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset fail", int'(fail), 0);
    chk("R1 reset attn", int'(attn), 0);
    chk("R1 reset bus write", int'(bus_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle reads flags", int'(bus_req && !bus_we && bus_addr == 2'd2), 1);

    dv_delay = 3;  full_xact("typical", 5, 6, 1);
    dv_delay = 1;  full_xact("min request", 2, 4, 7);
    dv_delay = 7;  full_xact("max request", 80, 3, 3);
    dv_delay = 40; full_xact("R8 slow device within window", 4, 5, 9);
    dv_delay = 2;

    // R2 rejections
    do_start(1, ok);
    chk("R2 length 1 rejected", int'(ok), 0);
    chk("R2 length 1 stays idle", int'(busy), 0);
    do_start(81, ok);
    chk("R2 length 81 rejected", int'(ok), 0);
    chk("R2 length 81 stays idle", int'(busy), 0);
    load_req(4, 5); set_resp(4);
    do_start(4, ok);
    chk("R2 start accepted", int'(ok), 1);
    @(negedge clk); start = 1'b1; start_len = 8'd4;
    #1 chk("R2 start while busy error", int'(start_err), 1);
    @(negedge clk); start = 1'b0;
    wait_end(gd, gf, c);
    chk("R2 first exchange completes", int'(gd), 1);

    // R6 one bad probe status
    load_req(3, 11); set_resp(4); dv_bad_probe = 1; p0 = n_probe;
    do_start(3, ok); wait_end(gd, gf, c);
    chk("R6 bad status recovers", int'(gd), 1);
    chk("R6 get-status issued twice", n_probe - p0, 2);

    // R6 one non-zero write-end code
    load_req(6, 21); set_resp(5); dv_wend_err = 1; p0 = n_probe; dv_req.delete();
    do_start(6, ok); wait_end(gd, gf, c);
    chk("R6 write-end error recovers", int'(gd), 1);
    chk("R6 restart count", n_probe - p0, 2);
    chk("R6 request resent from start", dv_req.size(), 12);
    read_res(80, 1, rl, rd);
    chk("R6 reply after restart", rd, int'(dv_resp[1]));

    // R7 persistent error
    load_req(3, 31); set_resp(4); dv_wend_err = 100; p0 = n_probe;
    do_start(3, ok); wait_end(gd, gf, c);
    chk("R7 failure reported", int'(gf), 1);
    chk("R7 attempts before failure", n_probe - p0, 4);
    @(negedge clk);
    chk("R7 idle after failure", int'(busy), 0);
    dv_wend_err = 0;
    full_xact("R7 usable after failure", 3, 3, 41);

    // R8 device stuck busy
    dv_stuck = 1; p0 = n_probe;
    load_req(3, 2); do_start(3, ok); wait_end(gd, gf, c);
    chk("R8 timeout leads to failure", int'(gf), 1);
    chk("R8 no command while busy", n_probe - p0, 0);
    chk("R8 timeout window respected", int'(c >= 4 * TMO), 1);
    dv_stuck = 0;

    // R9 overflow
    load_req(2, 3); set_resp(85);
    do_start(2, ok); wait_end(gd, gf, c);
    chk("R9 overflow exchange completes", int'(gd), 1);
    read_res(100, 0, rl, rd);
    chk("R9 length clipped", rl, 80);
    read_res(100, 2, rl, rd);
    chk("R9 byte 2 truncation code", rd, 8'hC6);
    read_res(100, 79, rl, rd);
    chk("R9 last kept byte", rd, int'(dv_resp[79]));

    // R10 short caller buffer
    load_req(2, 4); set_resp(10);
    do_start(2, ok); wait_end(gd, gf, c);
    read_res(5, 2, rl, rd);
    chk("R10 length equals capacity", rl, 5);
    chk("R10 byte 2 truncation code", rd, 8'hC6);
    read_res(5, 1, rl, rd);
    chk("R10 byte 1 intact", rd, int'(dv_resp[1]));
    read_res(10, 2, rl, rd);
    chk("R10 full capacity not truncated", rd, int'(dv_resp[2]));

    // R11 short reply
    load_req(2, 6); set_resp(2);
    do_start(2, ok); wait_end(gd, gf, c);
    read_res(10, 2, rl, rd);
    chk("R11 length forced to 3", rl, 3);
    chk("R11 byte 2 unspecified", rd, 8'hFF);
    read_res(10, 0, rl, rd);
    chk("R11 byte 0 intact", rd, int'(dv_resp[0]));

    // R12 attention
    dv_side = 8'h04; repeat (2) @(negedge clk);
    chk("R12 attention raised", int'(attn), 1);
    dv_side = 8'h18; repeat (2) @(negedge clk);
    chk("R12 bits 3 and 4 ignored", int'(attn), 0);
    chk("R12 no activity", int'(busy), 0);
    dv_side = 8'h00;

    // R13 absent device
    dv_absent = 1; repeat (2) @(negedge clk);
    chk("R13 absent detected", int'(absent), 1);
    dv_absent = 0; repeat (2) @(negedge clk);
    chk("R13 present again", int'(absent), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule